// File: doc/BRIEF.md
# Two-Bank Graphics Window Address Mapper

This block sits between a CPU bus and display memory. It claims only CPU accesses that fall inside the 64 KB graphics window at A0000h–AFFFFh. For each of those accesses it forms a 21-bit display memory address by adding a bank offset, counted in 4 KB pages, to the access's offset within the window. Accesses outside the window, and cycles with no access, are not claimed.

Two bank offset registers hold the page numbers. Bank A is 9 bits wide. Bank B is 8 bits wide. A control register holds a mapping mode bit and the ninth bit of bank A. In split mode, the half of the window that the address falls in picks the bank. In direction mode, the access direction picks the bank. Software loads all three registers through one narrow write port. The translated result is registered and appears one clock after the access is presented.

Top module: `bank_window_mapper`

## Requirements
- R1: While reset is asserted, `mem_hit` and `mem_addr` are zero. After reset, both bank registers and the mode bit are zero, so a read at A8000h maps to 008000h.
- R2: `mem_hit` is high in cycle k+1 only if `cpu_req` was high in cycle k and `cpu_addr[19:16]` equalled 4'hA.
- R3: When an access is outside the window, or `cpu_req` is low, `mem_hit` is low and `mem_addr` is zero in the following cycle.
- R4: With the mode bit set (direction mode), every read uses bank A and every write (`cpu_we`=1) uses bank B, whichever half of the window is addressed.
- R5: With the mode bit clear (split mode), offsets 0000h–7FFFh (`cpu_addr[15]`=0) use bank B and offsets 8000h–FFFFh use bank A, for reads and writes alike.
- R6: The output address is (bank × 4096 + `cpu_addr[15:0]`) modulo 2^21. Its low 12 bits always equal the access's low 12 address bits.
- R7: A write with `cfg_sel`=0 loads bank A bits 7:0, and a write with `cfg_sel`=1 loads the 8-bit bank B. A write with `cfg_sel`=2 loads the mode from `cfg_wdata[0]` and bank A bit 8 from `cfg_wdata[1]`.
- R8: A write with `cfg_sel`=3 changes no register.
- R9: A register write performed in cycle k affects accesses presented from cycle k+1 onward. An access presented in cycle k itself still uses the old values.
- R10: Each result is registered, so an access presented in cycle k shows on `mem_hit`/`mem_addr` after the clock edge that ends cycle k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 bank A low, 1 bank B, 2 control, 3 unused |
| cfg_wdata | input | 8 | Register write data |
| cpu_req | input | 1 | CPU memory access present this cycle |
| cpu_we | input | 1 | 1 for a write access, 0 for a read |
| cpu_addr | input | 20 | CPU memory address |
| mem_hit | output | 1 | Registered: previous access was claimed |
| mem_addr | output | 21 | Registered display memory address, zero when not claimed |

## Verification
The bench targets the half boundary at A7FFFh/A8000h. A mapper with the halves swapped would give those two addresses each other's bank. It also targets the window edges at 9FFFFh and B0000h, where a decoder that is too loose would claim a neighbour's address. It checks that direction mode ignores the half bit, and that an offset near the top of a high bank wraps modulo 2^21 rather than spilling a 22nd bit. It presents a register write and an access in the same cycle to catch a mapper that forwards new register values too early. It also writes to the unused select code, which must leave both banks and the mode unchanged.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  typedef enum logic [1:0] {
    CFG_BANK_A_LO = 2'd0,
    CFG_BANK_B    = 2'd1,
    CFG_CTRL      = 2'd2,
    CFG_UNUSED    = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    MAP_SPLIT = 1'b0,
    MAP_DIR   = 1'b1
  } map_mode_e;

  localparam int unsigned CTRL_MODE_BIT = 0;
  localparam int unsigned CTRL_AHI_LSB  = 1;
endpackage

// File: rtl/bwm_cfg_regs.sv
module bwm_cfg_regs
  import bwm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [BANK_W-1:0] bank_a,
  output logic [DATA_W-1:0] bank_b,
  output map_mode_e         map_mode
);
  localparam int unsigned HI_W = BANK_W - DATA_W;

  cfg_sel_e          sel_e;
  logic              en_a_lo, en_b, en_ctrl;
  logic [DATA_W-1:0] a_lo_q, a_lo_d;
  logic [HI_W-1:0]   a_hi_q, a_hi_d;
  logic [DATA_W-1:0] b_q, b_d;
  map_mode_e         mode_q, mode_d;

  assign sel_e = cfg_sel_e'(cfg_sel);

  always_comb begin
    en_a_lo = cfg_we && (sel_e == CFG_BANK_A_LO);
    en_b    = cfg_we && (sel_e == CFG_BANK_B);
    en_ctrl = cfg_we && (sel_e == CFG_CTRL);
    a_lo_d  = cfg_wdata;
    b_d     = cfg_wdata;
    a_hi_d  = cfg_wdata[CTRL_AHI_LSB +: HI_W];
    mode_d  = map_mode_e'(cfg_wdata[CTRL_MODE_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_lo_q <= '0;
      a_hi_q <= '0;
      b_q    <= '0;
      mode_q <= MAP_SPLIT;
    end else begin
      if (en_a_lo) a_lo_q <= a_lo_d;
      if (en_b)    b_q    <= b_d;
      if (en_ctrl) begin
        a_hi_q <= a_hi_d;
        mode_q <= mode_d;
      end
    end
  end

  assign bank_a   = {a_hi_q, a_lo_q};
  assign bank_b   = b_q;
  assign map_mode = mode_q;

  p_unused_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3) |=> ($stable(bank_a) && $stable(bank_b) && $stable(map_mode)));

  p_bank_b_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd1) |=> (bank_b == $past(cfg_wdata)));

  p_ctrl_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd2) |=>
      (bank_a[BANK_W-1 -: HI_W] == $past(cfg_wdata[CTRL_AHI_LSB +: HI_W])));
endmodule

// File: rtl/bwm_bank_select.sv
module bwm_bank_select
  import bwm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 9
) (
  input  map_mode_e         map_mode,
  input  logic              cpu_we,
  input  logic              upper_half,
  input  logic [BANK_W-1:0] bank_a,
  input  logic [DATA_W-1:0] bank_b,
  output logic [BANK_W-1:0] bank_sel
);
  logic [BANK_W-1:0] bank_b_ext;
  logic              use_a;

  assign bank_b_ext = BANK_W'(bank_b);

  always_comb begin
    if (map_mode == MAP_DIR) use_a = !cpu_we;
    else                     use_a = upper_half;
    bank_sel = use_a ? bank_a : bank_b_ext;
  end
endmodule

// File: rtl/bwm_addr_xlate.sv
module bwm_addr_xlate #(
  parameter int unsigned CPU_AW     = 20,
  parameter int unsigned MEM_AW     = 21,
  parameter int unsigned WIN_AW     = 16,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned BANK_W     = 9,
  parameter int unsigned WIN_TAG    = 'hA
) (
  input  logic              cpu_req,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              upper_half,
  output logic              hit,
  output logic [MEM_AW-1:0] mem_addr
);
  localparam int unsigned TAG_W  = CPU_AW - WIN_AW;
  localparam int unsigned BASE_W = BANK_W + PAGE_SHIFT;

  logic [TAG_W-1:0]  tag;
  logic [BASE_W-1:0] base_wide;
  logic [MEM_AW-1:0] base, offset, sum;

  always_comb begin
    tag        = cpu_addr[CPU_AW-1:WIN_AW];
    upper_half = cpu_addr[WIN_AW-1];
    hit        = cpu_req && (tag == TAG_W'(WIN_TAG));
    base_wide  = {bank_sel, {PAGE_SHIFT{1'b0}}};
    base       = MEM_AW'(base_wide);
    offset     = MEM_AW'(cpu_addr[WIN_AW-1:0]);
    sum        = base + offset;
    mem_addr   = hit ? sum : '0;
  end
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
  import bwm_pkg::*;
#(
  parameter int unsigned CPU_AW     = 20,
  parameter int unsigned MEM_AW     = 21,
  parameter int unsigned WIN_AW     = 16,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BANK_W     = 9,
  parameter int unsigned WIN_TAG    = 'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic              mem_hit,
  output logic [MEM_AW-1:0] mem_addr
);
  localparam int unsigned TAG_W = CPU_AW - WIN_AW;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [BANK_W-1:0] bank_a, bank_sel;
  logic [DATA_W-1:0] bank_b;
  map_mode_e         map_mode;
  logic              upper_half, x_hit;
  logic [MEM_AW-1:0] x_addr;
  logic              hit_q, hit_d;
  logic [MEM_AW-1:0] addr_q, addr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bwm_cfg_regs #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bank_a(bank_a), .bank_b(bank_b), .map_mode(map_mode)
  );

  bwm_bank_select #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_sel (
    .map_mode(map_mode), .cpu_we(cpu_we), .upper_half(upper_half),
    .bank_a(bank_a), .bank_b(bank_b), .bank_sel(bank_sel)
  );

  bwm_addr_xlate #(
    .CPU_AW(CPU_AW), .MEM_AW(MEM_AW), .WIN_AW(WIN_AW),
    .PAGE_SHIFT(PAGE_SHIFT), .BANK_W(BANK_W), .WIN_TAG(WIN_TAG)
  ) u_xlate (
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .bank_sel(bank_sel),
    .upper_half(upper_half), .hit(x_hit), .mem_addr(x_addr)
  );

  always_comb begin
    hit_d  = x_hit;
    addr_d = x_addr;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hit_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      hit_q  <= hit_d;
      addr_q <= addr_d;
    end
  end

  assign mem_hit  = hit_q;
  assign mem_addr = addr_q;

  p_claim_window_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_hit |-> ($past(cpu_req) && ($past(cpu_addr[CPU_AW-1:WIN_AW]) == TAG_W'(WIN_TAG))));

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mem_hit |-> (mem_addr == '0));

  p_page_offset_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_hit |-> (mem_addr[PAGE_SHIFT-1:0] == $past(cpu_addr[PAGE_SHIFT-1:0])));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!mem_hit && mem_addr == '0));
endmodule

// File: tb/bank_window_mapper_test.sv
module bank_window_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [19:0] cpu_addr = 20'd0;
  logic        mem_hit;
  logic [20:0] mem_addr;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        hit;
    logic [20:0] addr;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [8:0] m_a = 9'd0;
  logic [7:0] m_b = 8'd0;
  logic       m_dir = 1'b0;

  always #5 clk = ~clk;

  bank_window_mapper uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .mem_hit(mem_hit), .mem_addr(mem_addr)
  );

  task automatic check(input bit ok, input string tag, input logic [21:0] act, input logic [21:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual hit/addr=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic req, input logic we, input logic [19:0] a, input string tag);
    exp_t e;
    logic [8:0]  bank;
    logic [21:0] full;
    e.tag = tag;
    if (!req || a[19:16] != 4'hA) begin
      e.hit = 1'b0;
      e.addr = '0;
    end else begin
      if (m_dir) bank = we ? {1'b0, m_b} : m_a;
      else       bank = a[15] ? m_a : {1'b0, m_b};
      full = {1'b0, bank, 12'h000} + {6'd0, a[15:0]};
      e.hit = 1'b1;
      e.addr = full[20:0];
    end
    return e;
  endfunction

  task automatic model_write(input logic [1:0] sel, input logic [7:0] d);
    case (sel)
      2'd0: m_a[7:0] = d;
      2'd1: m_b = d;
      2'd2: begin m_dir = d[0]; m_a[8] = d[1]; end
      default: ;
    endcase
  endtask

  task automatic acc(input logic req, input logic we, input logic [19:0] a, input string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    cpu_req = req; cpu_we = we; cpu_addr = a;
    exp_q.push_back(model(req, we, a, tag));
  endtask

  task automatic wcfg(input logic [1:0] sel, input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = 20'hA0000;
    e.hit = 1'b0; e.addr = '0; e.tag = tag;
    exp_q.push_back(e);
    model_write(sel, d);
  endtask

  task automatic wcfg_acc(input logic [1:0] sel, input logic [7:0] d, input logic we,
                          input logic [19:0] a, input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
    exp_q.push_back(model(1'b1, we, a, tag));
    model_write(sel, d);
  endtask

  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(mem_hit === e.hit && mem_addr === e.addr, e.tag,
              {mem_hit, mem_addr}, {e.hit, e.addr});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mem_hit === 1'b0 && mem_addr === 21'd0, "R1 outputs in reset",
          {mem_hit, mem_addr}, 22'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    acc(1'b1, 1'b0, 20'hA0000, "R1 bank B zero after reset");
    acc(1'b1, 1'b0, 20'hA8000, "R1 bank A zero after reset");
    acc(1'b1, 1'b0, 20'h9FFFF, "R3 below window");
    acc(1'b1, 1'b1, 20'hB0000, "R3 above window");
    acc(1'b0, 1'b0, 20'hA1234, "R3 no request");
    acc(1'b1, 1'b0, 20'hAFFFF, "R2 top of window");

    wcfg(2'd1, 8'h12, "R7 load bank B");
    wcfg(2'd0, 8'h34, "R7 load bank A low");
    wcfg(2'd2, 8'h02, "R7 ctrl split with A bit 8");
    acc(1'b1, 1'b1, 20'hA7FFF, "R5 last low-half byte uses B");
    acc(1'b1, 1'b0, 20'hA8000, "R5 first high-half byte uses A");
    acc(1'b1, 1'b1, 20'hAC000, "R5 write in high half uses A");
    acc(1'b1, 1'b0, 20'hA0010, "R5 read in low half uses B");

    wcfg(2'd2, 8'h03, "R7 ctrl direction mode");
    acc(1'b1, 1'b0, 20'hA0000, "R4 read low half uses A");
    acc(1'b1, 1'b1, 20'hAFFFF, "R4 write high half uses B");
    acc(1'b1, 1'b0, 20'hAFFFF, "R4 read high half uses A");

    wcfg(2'd0, 8'hFF, "R7 bank A max");
    acc(1'b1, 1'b0, 20'hAFFFF, "R6 wrap modulo 2^21");
    acc(1'b1, 1'b0, 20'hA0ABC, "R6 low bits pass through");

    wcfg(2'd3, 8'h55, "R8 unused select write");
    acc(1'b1, 1'b0, 20'hA0000, "R8 bank A unchanged");
    acc(1'b1, 1'b1, 20'hA0000, "R8 bank B and mode unchanged");

    wcfg_acc(2'd1, 8'h40, 1'b1, 20'hA0100, "R9 same-cycle access uses old B");
    acc(1'b1, 1'b1, 20'hA0100, "R9 next access uses new B");

    wcfg(2'd2, 8'h01, "R7 clear A bit 8");
    acc(1'b1, 1'b0, 20'hA0000, "R7 A bit 8 cleared");
    acc(1'b1, 1'b1, 20'hA8123, "R10 result one cycle later");

    acc(1'b0, 1'b0, 20'h00000, "R3 idle tail");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule